// File: doc/BRIEF.md
# Supply Switch Sequencer with Status Timeout

This block decides when the chip's external supply path, fed by a power-management IC (PMIC), is actually in use. Software writes a 32-bit control word holding an enable bit and an 8-bit wait limit. When the path is wanted, the sequencer waits for the PMIC's status-good input before it reports the path as enabled. If the wait limit runs out first, it raises a one-cycle reset request.

The actual state can differ from the software enable bit. A deep-sleep entry turns the path off, and the matching wakeup brings it back if the enable bit is still set. A debugger power-up request keeps an enabled path on when software clears the bit, but it never turns on a path that is off. A sleep entry that arrives while the sequencer is mid-transition is held until the sequencer is idle. The wait limit is counted in ticks from a prescaler. Each tick stands for 128 µs of the internal oscillator.

Top module: `supply_seq_ctrl`

## Requirements
- R1: The control word resets to all zeros. It holds the wait limit in bits 7:0 and the enable bit at bit 31. All other bits read back as 0. A write shows in the readback on the cycle after the write strobe.
- R2: With the enable bit set and no sleep in force, the sequencer leaves the off state and waits for status-good. When status-good is high during the wait, the path-enabled output goes to 1 on the next cycle.
- R3: A wait limit of 0 disables the timeout. No number of ticks during the wait raises the reset request.
- R4: With a wait limit of N > 0, the N-th tick seen during the wait without status-good makes the reset request high for exactly one cycle. The sequencer is back in the off state in that same cycle.
- R5: A write with bit 31 set leaves the enable bit at 0 while the configured input is 0. The path stays off.
- R6: A deep-sleep entry pulse turns an enabled path off. A wakeup pulse re-enables it when the enable bit is set.
- R7: While the debugger request is high, clearing the enable bit leaves the path-enabled output at 1.
- R8: The debugger request never turns on a path that is off.
- R9: When the debugger request falls and the enable bit is 0, the sequencer disables the path.
- R10: The busy output is 1 while the sequencer waits for status-good and during its one-cycle disable step. It is 0 in the steady off and on states.
- R11: A deep-sleep entry pulse that arrives while busy is held. It takes effect once the sequencer reaches the off or on state.
- R12: Once status-good has been seen, later ticks never raise the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| ext_configured | input | 1 | External supply has been configured; gates the enable bit |
| pmic_good | input | 1 | PMIC status-good |
| tick_128us | input | 1 | One-cycle prescaler pulse, one per 128 µs |
| sleep_enter | input | 1 | Deep-sleep entry request pulse |
| sleep_wake | input | 1 | Wakeup request pulse |
| dbg_pwrup | input | 1 | Debugger power-up request level |
| path_on | output | 1 | Supply path actually enabled |
| seq_busy | output | 1 | Sequencer mid-transition |
| reset_req | output | 1 | One-cycle reset request on wait timeout |

## Verification
The enable path is driven in four ways: status-good held low against a non-zero limit, status-good late against a zero limit, status-good already high, and enable writes while the configured input is low. These separate timeout expiry, the disabled timeout, the normal turn-on and the gated write. Debugger levels are applied both with the path on and with it off, which tells a hold apart from a forced turn-on. Sleep pulses are sent in the steady on state and during a wait, which tells immediate entry apart from deferred entry. A behavioural model follows every input each cycle and is compared with all outputs.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_ON   = 2'd2,
        SEQ_DIS  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/supply_seq_regs.sv
module supply_seq_regs #(
    parameter int REG_W  = 32,
    parameter int LIM_W  = 8,
    parameter int EN_POS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             configured,
    output logic             en,
    output logic [LIM_W-1:0] limit,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        logic             en;
        logic [LIM_W-1:0] limit;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.limit = wdata[LIM_W-1:0];
            r_d.en    = wdata[EN_POS] & configured;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata                 = '0;
        rdata[LIM_W-1:0]      = r_q.limit;
        rdata[EN_POS]         = r_q.en;
    end

    assign en    = r_q.en;
    assign limit = r_q.limit;

    assert_cfg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !configured) |=> !en);
endmodule

// File: rtl/supply_seq_timer.sv
module supply_seq_timer #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LIM_W-1:0] load_val,
    input  logic             run,
    input  logic             good,
    input  logic             tick,
    output logic             expire
);
    localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

    logic [LIM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                              cnt_d = load_val;
        else if (run && good)                  cnt_d = '0;
        else if (run && tick && cnt_q != '0)   cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && !good && tick && (cnt_q == ONE);

    assert_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !expire);
endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       dbg,
    input  logic       sleep_enter,
    input  logic       sleep_wake,
    input  logic       good,
    input  logic       expire,
    output logic       load,
    output logic       run,
    output logic       path_on,
    output logic       busy,
    output logic       reset_req
);
    typedef struct packed {
        seq_state_e st;
        logic       asleep;
        logic       pend;
        logic       rst;
    } fsm_t;

    fsm_t f_d, f_q;
    logic want, idle, sleep_any;

    assign want      = en && !f_q.asleep;
    assign idle      = (f_q.st == SEQ_OFF) || (f_q.st == SEQ_ON);
    assign sleep_any = sleep_enter || f_q.pend;

    always_comb begin
        f_d     = f_q;
        f_d.rst = 1'b0;
        load    = 1'b0;
        unique case (f_q.st)
            SEQ_OFF: if (want) begin
                f_d.st = SEQ_WAIT;
                load   = 1'b1;
            end
            SEQ_WAIT: begin
                if (good)        f_d.st = SEQ_ON;
                else if (expire) begin
                    f_d.st  = SEQ_OFF;
                    f_d.rst = 1'b1;
                end
            end
            SEQ_ON:  if (!want && !dbg) f_d.st = SEQ_DIS;
            SEQ_DIS: f_d.st = SEQ_OFF;
            default: f_d.st = SEQ_OFF;
        endcase
        if (sleep_wake) begin
            f_d.asleep = 1'b0;
            f_d.pend   = 1'b0;
        end else if (sleep_any && idle) begin
            f_d.asleep = 1'b1;
            f_d.pend   = 1'b0;
        end else if (sleep_any) begin
            f_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: SEQ_OFF, asleep: 1'b0, pend: 1'b0, rst: 1'b0};
        else        f_q <= f_d;
    end

    assign run       = (f_q.st == SEQ_WAIT);
    assign path_on   = (f_q.st == SEQ_ON);
    assign busy      = (f_q.st == SEQ_WAIT) || (f_q.st == SEQ_DIS);
    assign reset_req = f_q.rst;

    assert_rise_needs_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(path_on) |-> ($past(run) && $past(good)));
    assert_dbg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (path_on && dbg) |=> path_on);
    assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    assert_rst_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (!path_on && !busy));
endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl #(
    parameter int REG_W  = 32,
    parameter int LIM_W  = 8,
    parameter int EN_POS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             ext_configured,
    input  logic             pmic_good,
    input  logic             tick_128us,
    input  logic             sleep_enter,
    input  logic             sleep_wake,
    input  logic             dbg_pwrup,
    output logic             path_on,
    output logic             seq_busy,
    output logic             reset_req
);
    logic             en;
    logic [LIM_W-1:0] limit;
    logic             load, run, expire;

    supply_seq_regs #(.REG_W(REG_W), .LIM_W(LIM_W), .EN_POS(EN_POS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .configured(ext_configured), .en(en), .limit(limit), .rdata(ctl_rdata)
    );

    supply_seq_timer #(.LIM_W(LIM_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(limit), .run(run),
        .good(pmic_good), .tick(tick_128us), .expire(expire)
    );

    supply_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .dbg(dbg_pwrup),
        .sleep_enter(sleep_enter), .sleep_wake(sleep_wake), .good(pmic_good),
        .expire(expire), .load(load), .run(run), .path_on(path_on),
        .busy(seq_busy), .reset_req(reset_req)
    );

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !path_on);
    assert_good_no_rst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        path_on |-> !reset_req);
endmodule

// File: tb/supply_seq_ctrl_tb_top.sv
module supply_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        ext_configured = 1'b0, pmic_good = 1'b0, tick_128us = 1'b0;
    logic        sleep_enter = 1'b0, sleep_wake = 1'b0, dbg_pwrup = 1'b0;
    logic        path_on, seq_busy, reset_req;

    int checks = 0, failures = 0, rst_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    supply_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ext_configured(ext_configured),
        .pmic_good(pmic_good), .tick_128us(tick_128us),
        .sleep_enter(sleep_enter), .sleep_wake(sleep_wake),
        .dbg_pwrup(dbg_pwrup), .path_on(path_on), .seq_busy(seq_busy),
        .reset_req(reset_req)
    );

    // behavioural reference: mode 0 off, 1 waiting, 2 on, 3 disabling
    int          m_mode = 0, m_cnt = 0;
    bit          m_en = 0, m_slp = 0, m_pend = 0, m_rst = 0;
    logic [7:0]  m_lim = 0;

    always @(posedge clk) begin
        int  n_mode, n_cnt;
        bit  n_en, n_slp, n_pend, n_rst, want, idle;
        logic [7:0] n_lim;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_en = 0; m_slp = 0; m_pend = 0; m_rst = 0; m_lim = 0;
        end else begin
            want = m_en && !m_slp;
            idle = (m_mode == 0) || (m_mode == 2);
            n_mode = m_mode; n_cnt = m_cnt; n_rst = 0;
            n_en = m_en; n_lim = m_lim; n_slp = m_slp; n_pend = m_pend;
            if (m_mode == 0) begin
                if (want) begin n_mode = 1; n_cnt = m_lim; end
            end else if (m_mode == 1) begin
                if (pmic_good) begin n_mode = 2; n_cnt = 0; end
                else if (tick_128us && m_cnt > 0) begin
                    n_cnt = m_cnt - 1;
                    if (m_cnt == 1) begin n_rst = 1; n_mode = 0; end
                end
            end else if (m_mode == 2) begin
                if (!want && !dbg_pwrup) n_mode = 3;
            end else n_mode = 0;
            if (sleep_wake) begin n_slp = 0; n_pend = 0; end
            else if (sleep_enter || m_pend) begin
                if (idle) begin n_slp = 1; n_pend = 0; end
                else n_pend = 1;
            end
            if (ctl_wr) begin
                n_en = ctl_wdata[31] && ext_configured;
                n_lim = ctl_wdata[7:0];
            end
            m_mode = n_mode; m_cnt = n_cnt; m_rst = n_rst; m_en = n_en;
            m_lim = n_lim; m_slp = n_slp; m_pend = n_pend;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (reset_req) rst_seen++;
            chk(ctl_rdata == {m_en, 23'd0, m_lim}, "R1 model readback", ctl_rdata, {m_en, 23'd0, m_lim});
            chk(path_on == (m_mode == 2), "R2 model path_on", path_on, m_mode == 2);
            chk(seq_busy == (m_mode == 1 || m_mode == 3), "R10 model busy", seq_busy, m_mode == 1 || m_mode == 3);
            chk(reset_req == m_rst, "R4 model reset_req", reset_req, m_rst);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write(input logic [31:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic tick_once();
        tick_128us = 1'b1; step(1);
        tick_128us = 1'b0; step(2);
    endtask

    task automatic pulse_sleep(input bit wake);
        if (wake) sleep_wake = 1'b1; else sleep_enter = 1'b1;
        step(1);
        sleep_wake = 1'b0; sleep_enter = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(ctl_rdata == 0 && !path_on && !seq_busy && !reset_req, "R1 reset state", ctl_rdata, 0);

        // R5: enable gated by configured
        write(32'h8000_0005);
        step(3);
        chk(ctl_rdata == 32'h0000_0005, "R5 enable gated", ctl_rdata, 32'h5);
        chk(!path_on && !seq_busy, "R5 path stays off", path_on, 0);

        // R4: timeout with limit 3
        ext_configured = 1'b1;
        write(32'h8000_0003);
        step(2);
        chk(seq_busy == 1'b1, "R10 busy in wait", seq_busy, 1);
        tick_once(); tick_once();
        chk(rst_seen == 0, "R4 no reset before limit", rst_seen, 0);
        tick_once();
        chk(rst_seen == 1, "R4 reset after limit", rst_seen, 1);
        write(32'h0000_0000);
        pmic_good = 1'b1;
        step(6);
        pmic_good = 1'b0;
        chk(!path_on && !seq_busy, "R9 settle off", path_on, 0);

        // R3: zero limit never times out
        write(32'h8000_0000);
        step(2);
        for (int i = 0; i < 10; i++) tick_once();
        chk(rst_seen == 1 && seq_busy, "R3 no timeout with zero limit", rst_seen, 1);
        pmic_good = 1'b1;
        step(1);
        chk(path_on == 1'b1, "R2 on after status good", path_on, 1);
        for (int i = 0; i < 5; i++) tick_once();
        chk(rst_seen == 1 && path_on, "R12 ticks after good ignored", rst_seen, 1);

        // R7/R9: debugger hold then release
        dbg_pwrup = 1'b1;
        write(32'h0000_0000);
        step(4);
        chk(path_on == 1'b1, "R7 debugger holds on", path_on, 1);
        dbg_pwrup = 1'b0;
        step(1);
        chk(seq_busy == 1'b1, "R10 busy while disabling", seq_busy, 1);
        step(2);
        chk(!path_on && !seq_busy, "R9 disabled after release", path_on, 0);

        // R8: debugger never turns on
        dbg_pwrup = 1'b1;
        step(5);
        chk(!path_on && !seq_busy, "R8 no turn on by debugger", path_on, 0);
        dbg_pwrup = 1'b0;

        // R6: sleep and wake
        write(32'h8000_0000);
        step(4);
        chk(path_on == 1'b1, "R6 on before sleep", path_on, 1);
        pulse_sleep(0);
        step(5);
        chk(!path_on, "R6 off in sleep", path_on, 0);
        pulse_sleep(1);
        step(5);
        chk(path_on == 1'b1, "R6 on after wake", path_on, 1);

        // R11: sleep while busy is deferred
        write(32'h0000_0000);
        pmic_good = 1'b0;
        step(4);
        write(32'h8000_0000);
        step(2);
        pulse_sleep(0);
        step(3);
        chk(seq_busy && !path_on, "R11 still waiting", seq_busy, 1);
        pmic_good = 1'b1;
        step(8);
        chk(!path_on && !seq_busy, "R11 deferred sleep applied", path_on, 0);
        pulse_sleep(1);
        step(5);
        chk(path_on == 1'b1, "R11 on after wake", path_on, 1);

        // R1: unused bits read as zero
        write(32'h7FFF_FF5A);
        step(1);
        chk(ctl_rdata == 32'h0000_005A, "R1 field layout", ctl_rdata, 32'h5A);
        step(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule